// File: doc/BRIEF.md
# Periodic Cyclic Vector Rotator

This block sits between a polyphase filter bank and an M-point inverse DFT in an oversampled channelizer. Each incoming vector of M elements leaves with its elements circularly rotated. The rotation cancels the phase shifts that oversampling introduces. Those shifts depend on frequency and would otherwise appear on the transform outputs.

The rotation amount is not fixed. It steps through a periodic sequence, one step per accepted vector, and a small state machine tracks that sequence. The step size is S = M*Q/P. With M = 16 channels and an 8/7 oversampling ratio, S = 14, so the sequence is 0, 14, 12, 10, 8, 6, 4, 2 and it repeats every 8 vectors. The number of states is M / gcd(M, S mod M), and it is fixed when the design is elaborated.

The datapath stores no samples. Input and output are valid/ready vector streams, and the handshake passes straight through the block with no added latency.

Top module: `cvr_rotator`

## Requirements
- R1: `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`, in the same cycle.
- R2: Vector element i occupies bits [i*W +: W]. Output element i equals input element (i + shift) mod M, where shift is the rotation currently applied.
- R3: For the k-th accepted vector since reset (k counted from 0), shift = (k*14) mod 16 with the default parameters.
- R4: A vector is accepted only when `in_valid` and `out_ready` are both high at a rising clock edge. A cycle without acceptance leaves the rotation for the next vector unchanged.
- R5: A synchronous active-low reset returns the sequence to shift 0. This includes a reset applied in the middle of a sequence.
- R6: After 8 accepted vectors, the sequence wraps and the next vector is rotated by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can take the input vector |
| in_data | input | M*W | Input vector, element i at bits [i*W +: W] |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Downstream can take the output vector |
| out_data | output | M*W | Rotated output vector |

## Verification
On every cycle, the assertions check these behaviours:
- The rotation holds steady while no vector is accepted.
- The rotation advances by S modulo M on each acceptance.
- The sequence wraps to zero after the final state.
- Reset forces the rotation to zero.
- Output element 0 is taken from the input element selected by the current rotation.

Only the bench scenarios can show the rest:
- The full rotation sequence checked against the count of accepted vectors.
- Rotation of every element, not just element 0.
- The handshake pass-through.
- The effect of a reset in the middle of a sequence on the next vector.

// File: rtl/cvr_pkg.sv
// Package: cvr_pkg
// Shared helpers for the cyclic vector rotator. These are elaboration-time
// functions only and produce no hardware.
package cvr_pkg;

    // Greatest common divisor. Used to find the period of the rotation sequence.
    function automatic int cvr_gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Number of distinct rotation states for a step of `step` modulo `m`.
    function automatic int cvr_period(input int m, input int step);
        if (step == 0) return 1;
        return m / cvr_gcd(m, step);
    endfunction

    // Bit width that can index 0 .. n-1. Never less than 1.
    function automatic int cvr_idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cvr_phase_seq.sv
// Module: cvr_phase_seq
// State machine that produces the rotation amount for the current vector.
// It keeps a phase counter (0 .. PERIOD-1) and a running shift that grows by
// STEP modulo M on each accepted vector. On the last phase both return to 0.
// Assumes: STEP < M, and PERIOD = M / gcd(M, STEP).
module cvr_phase_seq #(
    parameter int M      = 16,
    parameter int STEP   = 14,
    parameter int PERIOD = 8,
    parameter int SHW    = 4,
    parameter int PHW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    output logic [SHW-1:0] shift,
    output logic [PHW-1:0] phase
);
    localparam int SUMW = SHW + 1;
    localparam logic [SUMW-1:0] M_V    = SUMW'(M);
    localparam logic [SUMW-1:0] STEP_V = SUMW'(STEP);
    localparam logic [PHW-1:0]  LAST   = PHW'(PERIOD - 1);

    logic [SUMW-1:0] sum;
    logic [SHW-1:0]  shift_nxt;

    // Add the step to the current shift and reduce modulo M.
    always_comb begin
        sum       = {1'b0, shift} + STEP_V;
        shift_nxt = (sum >= M_V) ? SHW'(sum - M_V) : SHW'(sum);
    end

    // Phase and shift registers. They move only when a vector is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            shift <= '0;
        end else if (advance) begin
            if (phase == LAST) begin
                phase <= '0;
                shift <= '0;
            end else begin
                phase <= phase + 1'b1;
                shift <= shift_nxt;
            end
        end
    end

endmodule

// File: rtl/cvr_log_rotator.sv
// Module: cvr_log_rotator
// Combinational circular rotator with log2(M) stages. Stage j rotates by
// 2^j elements when bit j of `amount` is set. Output element i takes input
// element (i + amount) mod M. Assumes M >= 2 and amount < M.
module cvr_log_rotator #(
    parameter int M   = 16,
    parameter int W   = 16,
    parameter int SHW = 4
) (
    input  logic [M*W-1:0] din,
    input  logic [SHW-1:0] amount,
    output logic [M*W-1:0] dout
);
    logic [M*W-1:0] stage [0:SHW];

    assign stage[0] = din;

    for (genvar j = 0; j < SHW; j++) begin : g_stage
        localparam int STRIDE = (1 << j) % M;
        for (genvar i = 0; i < M; i++) begin : g_elem
            localparam int SRC = (i + STRIDE) % M;
            // Take the element from one stride ahead when this stage is active.
            assign stage[j+1][i*W +: W] =
                amount[j] ? stage[j][SRC*W +: W] : stage[j][i*W +: W];
        end
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/cvr_rotator.sv
// Module: cvr_rotator (top)
// Applies a periodically varying circular rotation to each M-element vector.
// The step per vector is S = (M*Q/P) mod M. The handshake passes straight
// through, and the datapath holds no samples.
// Assumes: M*Q is divisible by P, and M >= 2.
module cvr_rotator #(
    parameter int M = 16,
    parameter int W = 16,
    parameter int P = 8,
    parameter int Q = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [M*W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [M*W-1:0] out_data
);
    import cvr_pkg::*;

    localparam int STEP   = ((M * Q) / P) % M;
    localparam int PERIOD = cvr_period(M, STEP);
    localparam int SHW    = cvr_idx_w(M);
    localparam int PHW    = cvr_idx_w(PERIOD);

    logic           accept;
    logic [SHW-1:0] cur_shift;
    logic [PHW-1:0] cur_phase;

    // Handshake pass-through; a vector counts as accepted on valid and ready.
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign accept    = in_valid && out_ready;

    cvr_phase_seq #(
        .M(M), .STEP(STEP), .PERIOD(PERIOD), .SHW(SHW), .PHW(PHW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept),
        .shift   (cur_shift),
        .phase   (cur_phase)
    );

    cvr_log_rotator #(
        .M(M), .W(W), .SHW(SHW)
    ) u_rot (
        .din    (in_data),
        .amount (cur_shift),
        .dout   (out_data)
    );

endmodule

// File: rtl/cvr_rotator_chk.sv
// Module: cvr_rotator_chk
// Checker bound to cvr_rotator. It watches the ports and the state of the
// sequencer.
module cvr_rotator_chk #(
    parameter int M      = 16,
    parameter int W      = 16,
    parameter int STEP   = 14,
    parameter int PERIOD = 8,
    parameter int SHW    = 4,
    parameter int PHW    = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           out_ready,
    input logic [M*W-1:0] in_data,
    input logic [M*W-1:0] out_data,
    input logic [SHW-1:0] shift,
    input logic [PHW-1:0] phase
);
    logic acc;
    assign acc = in_valid && out_ready;

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(shift) && $stable(phase)); // R4

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && phase != PHW'(PERIOD-1)) |=>
        (int'(shift) == (int'($past(shift)) + STEP) % M)); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && phase == PHW'(PERIOD-1)) |=> (shift == '0 && phase == '0)); // R6

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (shift == '0 && phase == '0)); // R5

    AST_ELEM0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (out_data[0 +: W] == in_data[int'(shift)*W +: W])); // R2

endmodule

bind cvr_rotator cvr_rotator_chk #(
    .M(M), .W(W), .STEP(STEP), .PERIOD(PERIOD), .SHW(SHW), .PHW(PHW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_data   (in_data),
    .out_data  (out_data),
    .shift     (cur_shift),
    .phase     (cur_phase)
);

// File: tb/cvr_rotator_tb.sv
module cvr_rotator_tb;
    localparam int M    = 16;
    localparam int W    = 16;
    localparam int P    = 8;
    localparam int Q    = 7;
    localparam int STEP = ((M * Q) / P) % M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [M*W-1:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [M*W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #4 clk = ~clk;

    cvr_rotator #(.M(M), .W(W), .P(P), .Q(Q)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // R3: expected rotation of the k-th accepted vector.
    function automatic int exp_shift(input int idx);
        return (idx * STEP) % M;
    endfunction

    // R2: expected output vector for a given rotation.
    function automatic logic [M*W-1:0] exp_rot(input logic [M*W-1:0] v, input int sh);
        logic [M*W-1:0] r;
        for (int i = 0; i < M; i++) r[i*W +: W] = v[((i + sh) % M)*W +: W];
        return r;
    endfunction

    // Random data whose low byte carries the element index.
    function automatic logic [M*W-1:0] rand_vec();
        logic [M*W-1:0] v;
        for (int i = 0; i < M; i++) v[i*W +: W] = {8'($urandom), 8'(i)};
        return v;
    endfunction

    // Drive one cycle starting at the falling edge, check the outputs, then
    // update the model at the rising edge.
    task automatic cycle(input bit v, input bit r, input string tag);
        logic [M*W-1:0] e;
        in_data   = rand_vec();
        in_valid  = v;
        out_ready = r;
        #2;
        checks++;
        if (out_valid !== v || in_ready !== r) begin
            errors++;
            $display("FAIL R1 handshake: out_valid=%0b in_ready=%0b expected %0b %0b",
                     out_valid, in_ready, v, r);
        end
        if (v) begin
            e = exp_rot(in_data, exp_shift(k));
            checks++;
            if (out_data !== e) begin
                errors++;
                $display("FAIL %s rotation k=%0d: got %h expected %h", tag, k, out_data, e);
            end
        end
        @(posedge clk);
        if (v && r) k++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        k = 0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        @(negedge clk);
        do_reset();
        // R5: first vector after reset is unrotated.
        cycle(1'b1, 1'b1, "R5");
        // R3 and R6: full period and wrap back to zero.
        for (int n = 0; n < 9; n++) cycle(1'b1, 1'b1, (n == 7) ? "R6" : "R3");
        // R4: stalls by valid low and by ready low keep the rotation.
        cycle(1'b0, 1'b1, "R4");
        cycle(1'b1, 1'b0, "R4");
        cycle(1'b1, 1'b0, "R4");
        cycle(1'b1, 1'b1, "R4");
        // R5: reset in mid sequence.
        cycle(1'b1, 1'b1, "R3");
        cycle(1'b1, 1'b1, "R3");
        do_reset();
        cycle(1'b1, 1'b1, "R5");
        // Random valid and ready for the rest.
        for (int n = 0; n < 400; n++)
            cycle(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), "R2");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule